// File: doc/BRIEF.md
# Configurable Pulse Counter with Event Reporting

This block counts rising edges on one asynchronous pulse input. A two-flop synchronizer feeds an edge detector, and the edges go into a saturating counter, `CNT_W` bits wide (24 by default). A host configures the block with an 8-byte command frame on a byte stream. The block answers every accepted frame with an 8-byte response frame that carries the echo tag and a status code.

There are three stop conditions.
- Free-running: the counter runs up to the maximum.
- Window: edges are counted only for a programmed number of 10 ms ticks.
- Threshold: counting stops once a programmed number of edges has been seen.

A configuration can also leave the counter parked until a resume strobe arrives. Event strobes, each with a cause code, report a reached limit or a saturated count. An optional period value re-reports an event every N ticks.

Top module: `pulse_tally`

## Requirements
- R1: A frame is accepted only under all of these conditions:
  - `cmd_frame` stays high for 8 consecutive cycles carrying bytes 0..7.
  - Byte 0 is 0x1D.
  - Byte 2 bit 0 equals `INST_ID`.
  - Any other frame, including a frame cut short, gives no response and leaves the count and settings unchanged.
- R2: The response starts on the second clock edge after the last command byte and holds `rsp_valid` high for 8 cycles. The bytes are 0x1D, then the echo (command byte 1), then the status, then five zero bytes.
- R3: Mode is command byte 3 bits 7..4. A mode above 2 gives status 0x0A and leaves the count, mode and enable unchanged. A valid mode gives status 0x00.
- R4: A rising edge of `pulse_in` increments `count` on the third clock edge that samples `pulse_in` high.
- R5: Mode 0 counts freely and saturates at 2^CNT_W−1 (16,777,215 by default). If byte 3 bit 0 is set, `evt` pulses with cause 2 in the cycle the count reaches the maximum.
- R6: Mode 2 stops counting when the count equals LIMIT. LIMIT is byte 5 (LSB), byte 6 and byte 7 (MSB). If byte 3 bit 2 is set, an event with cause 1 is raised at that point.
- R7: Mode 1 counts edges only until LIMIT `tick_10ms` pulses have occurred since the counter started. The expiring tick stops counting and, if byte 3 bit 2 is set, raises an event with cause 1.
- R8: Byte 3 bit 2 has no effect in mode 0. With byte 3 bits 2 and 0 clear, reaching a limit or the maximum raises no event.
- R9: With byte 2 bit 2 set, the counter holds its count at zero until a `resume` strobe, and then counts. A `resume` while not parked has no effect.
- R10: With byte 2 bit 1 (enable) clear, `count` stays zero and no events occur, regardless of pulses, ticks or resume strobes.
- R11: A nonzero byte 4 value N raises an event with cause 3 every N ticks while the counter is enabled and not parked. When several causes fire in the same cycle, cause 1 has priority over cause 2, and cause 2 over cause 3.
- R12: After reset, `count` is 0, `evt` is low, `rsp_valid` is low and the counter is disabled. Every accepted configuration clears the count, the tick window and the period timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_10ms | input | 1 | One-cycle 10 ms time-base enable |
| pulse_in | input | 1 | Asynchronous pulse input |
| cmd_byte | input | 8 | Command byte stream |
| cmd_frame | input | 1 | High while command bytes are presented, one per cycle |
| resume | input | 1 | Strobe that releases a parked counter |
| count | output | CNT_W | Current pulse count |
| evt | output | 1 | One-cycle event strobe |
| evt_cause | output | 2 | Event cause: 1 limit, 2 maximum, 3 periodic |
| rsp_valid | output | 1 | High while response bytes are presented |
| rsp_byte | output | 8 | Response byte stream |

## Verification
The bench targets these corner cases:
- A pulse on the very tick that closes a time window. A design with the wrong order would miss or add one count.
- A threshold edge that is also the saturating edge. A design with the priority inverted would report the wrong cause.
- Frames with a wrong opcode, a wrong instance bit or a short length. A lax decoder would reconfigure on these or send a stray response.
- A rejected mode arriving in the middle of counting, which must not disturb the count.
- Resume strobes sent to a counter that is not parked, and to one that is disabled. Either would wrongly start counting if not ignored.

// File: rtl/pt_pkg.sv
`timescale 1ns/1ps
package pt_pkg;
  localparam logic [7:0] CFG_OPCODE  = 8'h1D;
  localparam logic [7:0] ST_OK       = 8'h00;
  localparam logic [7:0] ST_BAD_MODE = 8'h0A;

  localparam logic [3:0] MODE_FREE   = 4'd0;
  localparam logic [3:0] MODE_WINDOW = 4'd1;
  localparam logic [3:0] MODE_THRESH = 4'd2;

  typedef enum logic [1:0] {
    EV_NONE     = 2'd0,
    EV_LIMIT    = 2'd1,
    EV_MAXED    = 2'd2,
    EV_PERIODIC = 2'd3
  } ev_cause_e;

  typedef struct packed {
    logic [7:0]  echo;
    logic        park;
    logic        enable;
    logic [3:0]  mode;
    logic        ev_limit;
    logic        ev_max;
    logic [7:0]  period;
    logic [23:0] limit;
  } cfg_t;

  function automatic logic mode_ok(input logic [3:0] m);
    return (m == MODE_FREE) || (m == MODE_WINDOW) || (m == MODE_THRESH);
  endfunction

  // true when one more step brings v up to goal
  function automatic logic reaches(input logic [31:0] v, input logic [31:0] goal);
    return (v + 32'd1) == goal;
  endfunction
endpackage

// File: rtl/pt_sync_edge.sv
`timescale 1ns/1ps
module pt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pt_cmd_rx.sv
`timescale 1ns/1ps
module pt_cmd_rx
  import pt_pkg::*;
#(
  parameter bit INST_ID = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cmd_byte,
  input  logic       cmd_frame,
  output logic       apply,
  output cfg_t       cfg
);
  logic [3:0]  idx;
  logic [7:0]  op_q, echo_q, per_q;
  logic        park_q, en_q, inst_q, evl_q, evm_q;
  logic [3:0]  mode_q;
  logic [23:0] lim_q;
  logic        apply_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0; op_q <= '0; echo_q <= '0; per_q <= '0;
      park_q <= 1'b0; en_q <= 1'b0; inst_q <= 1'b0; evl_q <= 1'b0; evm_q <= 1'b0;
      mode_q <= '0; lim_q <= '0; apply_q <= 1'b0;
    end else begin
      apply_q <= cmd_frame && (idx == 4'd7) && (op_q == CFG_OPCODE) && (inst_q == INST_ID);
      if (!cmd_frame) idx <= '0;
      else if (idx != 4'd8) idx <= idx + 4'd1;
      if (cmd_frame) begin
        case (idx)
          4'd0: op_q   <= cmd_byte;
          4'd1: echo_q <= cmd_byte;
          4'd2: begin park_q <= cmd_byte[2]; en_q <= cmd_byte[1]; inst_q <= cmd_byte[0]; end
          4'd3: begin mode_q <= cmd_byte[7:4]; evl_q <= cmd_byte[2]; evm_q <= cmd_byte[0]; end
          4'd4: per_q  <= cmd_byte;
          4'd5: lim_q[7:0]   <= cmd_byte;
          4'd6: lim_q[15:8]  <= cmd_byte;
          4'd7: lim_q[23:16] <= cmd_byte;
          default: ;
        endcase
      end
    end
  end

  assign apply = apply_q;
  assign cfg = '{echo: echo_q, park: park_q, enable: en_q, mode: mode_q,
                 ev_limit: evl_q, ev_max: evm_q, period: per_q, limit: lim_q};

  assert_apply_after_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    apply |-> $past(cmd_frame));
endmodule

// File: rtl/pt_rsp_tx.sv
`timescale 1ns/1ps
module pt_rsp_tx
  import pt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] echo,
  input  logic [7:0] status,
  output logic       rsp_valid,
  output logic [7:0] rsp_byte
);
  logic       busy;
  logic [2:0] pos;
  logic [7:0] echo_q, st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; pos <= '0; echo_q <= '0; st_q <= '0;
    end else if (start) begin
      busy <= 1'b1; pos <= '0; echo_q <= echo; st_q <= status;
    end else if (busy) begin
      pos <= pos + 3'd1;
      if (pos == 3'd7) busy <= 1'b0;
    end
  end

  always_comb begin
    rsp_byte = 8'h00;
    if (busy) begin
      case (pos)
        3'd0:    rsp_byte = CFG_OPCODE;
        3'd1:    rsp_byte = echo_q;
        3'd2:    rsp_byte = st_q;
        default: rsp_byte = 8'h00;
      endcase
    end
  end
  assign rsp_valid = busy;

  assert_rsp_header_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (rsp_byte == CFG_OPCODE));
  assert_rsp_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> rsp_valid);
endmodule

// File: rtl/pt_core.sv
`timescale 1ns/1ps
module pt_core
  import pt_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  cfg_t             cfg,
  input  logic             rise,
  input  logic             tick,
  input  logic             resume,
  output logic [CNT_W-1:0] cnt,
  output logic             evt,
  output logic [1:0]       cause
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             on_q, run_q, hold_q, evl_q, evm_q;
  logic [3:0]       mode_q;
  logic [7:0]       per_q, rcnt_q;
  logic [23:0]      lim_q, tmr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             evt_q;
  ev_cause_e        cause_q, cause_d;

  // named internal events
  logic             cfg_take, wake, active, cnt_step, max_hit, thr_hit, win_expire, rep_fire;
  logic [CNT_W-1:0] cnt_nx;

  assign cfg_take   = apply && mode_ok(cfg.mode);
  assign wake       = !cfg_take && resume && hold_q;
  assign active     = on_q && !cfg_take && !wake;
  assign cnt_step   = active && run_q && rise && (cnt_q != CNT_MAX);
  assign cnt_nx     = cnt_q + CNT_W'(1);
  assign max_hit    = cnt_step && (cnt_nx == CNT_MAX);
  assign thr_hit    = cnt_step && (mode_q == MODE_THRESH) && (32'(cnt_nx) == 32'(lim_q));
  assign win_expire = active && run_q && tick && (mode_q == MODE_WINDOW)
                      && reaches(32'(tmr_q), 32'(lim_q));
  assign rep_fire   = active && !hold_q && (per_q != 8'd0) && tick
                      && reaches(32'(rcnt_q), 32'(per_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= 1'b0; run_q <= 1'b0; hold_q <= 1'b0; evl_q <= 1'b0; evm_q <= 1'b0;
      mode_q <= '0; per_q <= '0; lim_q <= '0;
      cnt_q <= '0; tmr_q <= '0; rcnt_q <= '0;
    end else if (cfg_take) begin
      on_q   <= cfg.enable;
      run_q  <= cfg.enable && !cfg.park;
      hold_q <= cfg.enable && cfg.park;
      evl_q  <= cfg.ev_limit;
      evm_q  <= cfg.ev_max;
      mode_q <= cfg.mode;
      per_q  <= cfg.period;
      lim_q  <= cfg.limit;
      cnt_q  <= '0; tmr_q <= '0; rcnt_q <= '0;
    end else if (wake) begin
      run_q  <= 1'b1;
      hold_q <= 1'b0;
    end else if (on_q) begin
      if (cnt_step) cnt_q <= cnt_nx;
      if (thr_hit || win_expire) run_q <= 1'b0;
      if (run_q && tick && (mode_q == MODE_WINDOW)) tmr_q <= tmr_q + 24'd1;
      if (tick && !hold_q && (per_q != 8'd0)) rcnt_q <= rep_fire ? 8'd0 : rcnt_q + 8'd1;
    end
  end

  always_comb begin
    if ((thr_hit || win_expire) && evl_q) cause_d = EV_LIMIT;
    else if (max_hit && evm_q)            cause_d = EV_MAXED;
    else if (rep_fire)                    cause_d = EV_PERIODIC;
    else                                  cause_d = EV_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0; cause_q <= EV_NONE;
    end else begin
      evt_q <= (cause_d != EV_NONE); cause_q <= cause_d;
    end
  end

  assign cnt   = cnt_q;
  assign evt   = evt_q;
  assign cause = cause_q;

  assert_sat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !cfg_take) |=> (cnt_q == CNT_MAX));
  assert_off_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !on_q |-> (cnt_q == '0 && !evt_q));
  assert_park_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_q && hold_q));
  assert_reject_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !mode_ok(cfg.mode)) |=> (mode_q == $past(mode_q) && on_q == $past(on_q)));
  assert_stopped_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cfg_take) |=> $stable(cnt_q));
endmodule

// File: rtl/pulse_tally.sv
`timescale 1ns/1ps
module pulse_tally
  import pt_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2,
  parameter bit INST_ID     = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_10ms,
  input  logic             pulse_in,
  input  logic [7:0]       cmd_byte,
  input  logic             cmd_frame,
  input  logic             resume,
  output logic [CNT_W-1:0] count,
  output logic             evt,
  output logic [1:0]       evt_cause,
  output logic             rsp_valid,
  output logic [7:0]       rsp_byte
);
  logic       rise, apply;
  cfg_t       cfg;
  logic [7:0] status;

  pt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pulse_in), .rise(rise));

  pt_cmd_rx #(.INST_ID(INST_ID)) u_rx (
    .clk(clk), .rst_n(rst_n), .cmd_byte(cmd_byte), .cmd_frame(cmd_frame),
    .apply(apply), .cfg(cfg));

  assign status = mode_ok(cfg.mode) ? ST_OK : ST_BAD_MODE;

  pt_rsp_tx u_tx (
    .clk(clk), .rst_n(rst_n), .start(apply), .echo(cfg.echo), .status(status),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte));

  pt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .apply(apply), .cfg(cfg), .rise(rise),
    .tick(tick_10ms), .resume(resume), .cnt(count), .evt(evt), .cause(evt_cause));
endmodule

// File: tb/pulse_tally_tb_top.sv
`timescale 1ns/1ps
module pulse_tally_tb_top;
  localparam int W    = 10;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_10ms = 1'b0, pulse_in = 1'b0, cmd_frame = 1'b0, resume = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [W-1:0] count;
  logic evt, rsp_valid;
  logic [1:0] evt_cause;
  logic [7:0] rsp_byte;

  always #2.5 clk = ~clk;

  pulse_tally #(.CNT_W(W), .SYNC_STAGES(2), .INST_ID(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_10ms(tick_10ms), .pulse_in(pulse_in),
    .cmd_byte(cmd_byte), .cmd_frame(cmd_frame), .resume(resume),
    .count(count), .evt(evt), .evt_cause(evt_cause),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte));

  int vectors = 0, miscompares = 0;
  string tag = "R12";
  int ev_seen [4];
  logic [7:0] rsp_seen [$];
  bit done = 0;

  // ---------------- behavioural reference model ----------------
  int p1, p2, p3;
  bit m_apply;
  logic [7:0] fq [$];
  logic [7:0] fb [8];
  bit m_on, m_run, m_susp, m_evl, m_evo;
  int m_mode, m_per, m_lim, m_cnt, m_tmr, m_rc;
  bit e_evt; int e_cause;
  logic [7:0] rq [$];

  task automatic model_reset();
    p1 = 0; p2 = 0; p3 = 0; m_apply = 0; fq.delete(); rq.delete();
    for (int i = 0; i < 8; i++) fb[i] = 8'h00;
    m_on = 0; m_run = 0; m_susp = 0; m_evl = 0; m_evo = 0;
    m_mode = 0; m_per = 0; m_lim = 0; m_cnt = 0; m_tmr = 0; m_rc = 0;
    e_evt = 0; e_cause = 0;
  endtask

  task automatic model_step();
    bit edge_now, ap, ev_l, ev_m, ev_r, was_run;
    int mo;
    edge_now = (p2 == 1) && (p3 == 0);
    p3 = p2; p2 = p1; p1 = int'(pulse_in);
    ap = m_apply;
    mo = int'(fb[3][7:4]);
    if (rq.size() > 0) rq.delete(0);
    if (ap) rq = '{8'h1D, fb[1], (mo > 2) ? 8'h0A : 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    ev_l = 0; ev_m = 0; ev_r = 0;
    if (ap && mo <= 2) begin
      m_on = fb[2][1]; m_run = fb[2][1] && !fb[2][2]; m_susp = fb[2][1] && fb[2][2];
      m_evl = fb[3][2]; m_evo = fb[3][0]; m_mode = mo; m_per = int'(fb[4]);
      m_lim = int'({fb[7], fb[6], fb[5]});
      m_cnt = 0; m_tmr = 0; m_rc = 0;
    end else if (resume && m_susp) begin
      m_run = 1; m_susp = 0;
    end else if (m_on) begin
      was_run = m_run;
      if (was_run && edge_now && m_cnt < MAXV) begin
        m_cnt++;
        if (m_cnt == MAXV) ev_m = 1;
        if (m_mode == 2 && m_cnt == m_lim) begin m_run = 0; ev_l = 1; end
      end
      if (was_run && tick_10ms && m_mode == 1) begin
        m_tmr++;
        if (m_tmr == m_lim) begin m_run = 0; ev_l = 1; end
      end
      if (m_per != 0 && !m_susp && tick_10ms) begin
        m_rc++;
        if (m_rc == m_per) begin m_rc = 0; ev_r = 1; end
      end
    end
    e_evt = (ev_l && m_evl) || (ev_m && m_evo) || ev_r;
    e_cause = (ev_l && m_evl) ? 1 : (ev_m && m_evo) ? 2 : ev_r ? 3 : 0;
    m_apply = 0;
    if (cmd_frame) begin
      if (fq.size() < 8) begin
        fq.push_back(cmd_byte);
        if (fq.size() == 8) begin
          for (int i = 0; i < 8; i++) fb[i] = fq[i];
          m_apply = (fq[0] == 8'h1D) && (fq[2][0] == 1'b0);
        end
      end
    end else fq.delete();
  endtask

  task automatic fail_line(input string what, input int act, input int exp);
    miscompares++;
    $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
    #1;
    if (!done) begin
      vectors++;
      if (int'(count) != m_cnt) fail_line("count", int'(count), m_cnt);
      if (evt != e_evt) fail_line("evt", int'(evt), int'(e_evt));
      if (evt && e_evt && int'(evt_cause) != e_cause) fail_line("evt_cause", int'(evt_cause), e_cause);
      if (rsp_valid != (rq.size() > 0)) fail_line("rsp_valid", int'(rsp_valid), int'(rq.size() > 0));
      if (rsp_valid && rq.size() > 0 && rsp_byte != rq[0]) fail_line("rsp_byte", int'(rsp_byte), int'(rq[0]));
      if (evt) ev_seen[evt_cause]++;
      if (rsp_valid) rsp_seen.push_back(rsp_byte);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input bit ok, input string rq_tag, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", rq_tag, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] op, input logic [7:0] echo, input logic [7:0] flags,
                      input logic [7:0] modeb, input logic [7:0] per, input int lim, input int n);
    logic [7:0] b [8];
    b = '{op, echo, flags, modeb, per, lim[7:0], lim[15:8], lim[23:16]};
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cmd_frame = 1'b1; cmd_byte = b[i];
    end
    @(negedge clk); cmd_frame = 1'b0; cmd_byte = 8'h00;
  endtask

  task automatic cfg(input logic [7:0] echo, input logic [7:0] flags, input logic [7:0] modeb,
                     input logic [7:0] per, input int lim);
    send(8'h1D, echo, flags, modeb, per, lim, 8);
    idle(12);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pulse_in = 1'b1; @(negedge clk);
      @(negedge clk); pulse_in = 1'b0; @(negedge clk);
    end
    idle(5);
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_10ms = 1'b1;
      @(negedge clk); tick_10ms = 1'b0;
      idle(gap - 2);
    end
  endtask

  task automatic kick();
    @(negedge clk); resume = 1'b1; @(negedge clk); resume = 1'b0; idle(2);
  endtask

  task automatic clear_seen();
    for (int i = 0; i < 4; i++) ev_seen[i] = 0;
    rsp_seen.delete();
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(100000 * 5);
    miscompares++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
    finish_run();
  end

  initial begin
    clear_seen();
    idle(3);
    tag = "R12";
    chk(count == 0 && !evt && !rsp_valid, "R12", "reset state", int'(count), 0);
    @(negedge clk); rst_n = 1'b1; idle(2);

    tag = "R10"; clear_seen();
    cfg(8'h11, 8'h00, 8'h05, 8'h02, 0);
    pulses(5); ticks(4, 3); kick();
    chk(count == 0, "R10", "disabled count", int'(count), 0);
    chk(ev_seen[1] + ev_seen[2] + ev_seen[3] == 0, "R10", "disabled events", ev_seen[3], 0);

    tag = "R2"; clear_seen();
    cfg(8'h5A, 8'h02, 8'h00, 8'h00, 0);
    chk(rsp_seen.size() == 8, "R2", "response length", rsp_seen.size(), 8);
    if (rsp_seen.size() == 8) begin
      chk(rsp_seen[0] == 8'h1D, "R2", "rsp id", int'(rsp_seen[0]), 29);
      chk(rsp_seen[1] == 8'h5A, "R2", "rsp echo", int'(rsp_seen[1]), 90);
      chk(rsp_seen[2] == 8'h00, "R3", "status ok", int'(rsp_seen[2]), 0);
    end
    tag = "R4";
    pulses(5);
    chk(count == 5, "R4", "edge count", int'(count), 5);

    tag = "R1"; clear_seen();
    send(8'h1C, 8'h01, 8'h02, 8'h00, 8'h00, 0, 8); idle(12);
    send(8'h1D, 8'h02, 8'h03, 8'h00, 8'h00, 0, 8); idle(12);
    send(8'h1D, 8'h03, 8'h02, 8'h00, 8'h00, 0, 5); idle(12);
    chk(rsp_seen.size() == 0, "R1", "no response to bad frames", rsp_seen.size(), 0);
    chk(count == 5, "R1", "count kept", int'(count), 5);

    tag = "R3"; clear_seen();
    cfg(8'h33, 8'h02, 8'h30, 8'h00, 0);
    chk(rsp_seen.size() == 8 && rsp_seen[2] == 8'h0A, "R3", "bad mode status",
        (rsp_seen.size() > 2) ? int'(rsp_seen[2]) : -1, 10);
    pulses(2);
    chk(count == 7, "R3", "counting kept", int'(count), 7);

    tag = "R5"; clear_seen();
    cfg(8'h44, 8'h02, 8'h01, 8'h00, 0);
    pulses(MAXV + 7);
    chk(count == MAXV, "R5", "saturation", int'(count), MAXV);
    chk(ev_seen[2] == 1, "R5", "overflow events", ev_seen[2], 1);

    tag = "R8"; clear_seen();
    cfg(8'h45, 8'h02, 8'h04, 8'h00, 0);
    pulses(MAXV + 7);
    chk(count == MAXV && ev_seen[1] + ev_seen[2] == 0, "R8", "free mode match ignored", ev_seen[1], 0);
    cfg(8'h46, 8'h02, 8'h20, 8'h00, 4);
    pulses(6);
    chk(count == 4 && ev_seen[1] == 0, "R8", "limit without event", int'(count), 4);

    tag = "R6"; clear_seen();
    cfg(8'h47, 8'h02, 8'h24, 8'h00, 20);
    pulses(30);
    chk(count == 20, "R6", "threshold stop", int'(count), 20);
    chk(ev_seen[1] == 1, "R6", "threshold event", ev_seen[1], 1);

    tag = "R7"; clear_seen();
    cfg(8'h48, 8'h02, 8'h14, 8'h00, 5);
    fork
      pulses(100);
      ticks(8, 20);
    join
    chk(count > 0 && count < 100, "R7", "window limited count", int'(count), 25);
    chk(ev_seen[1] == 1, "R7", "window event", ev_seen[1], 1);

    tag = "R9"; clear_seen();
    cfg(8'h49, 8'h06, 8'h00, 8'h00, 0);
    pulses(4);
    chk(count == 0, "R9", "parked count", int'(count), 0);
    kick(); pulses(3);
    chk(count == 3, "R9", "resumed count", int'(count), 3);
    kick(); pulses(1);
    chk(count == 4, "R9", "extra resume ignored", int'(count), 4);

    tag = "R11"; clear_seen();
    cfg(8'h4A, 8'h02, 8'h00, 8'h03, 0);
    ticks(10, 4); idle(4);
    chk(ev_seen[3] == 3, "R11", "periodic events", ev_seen[3], 3);
    cfg(8'h4B, 8'h02, 8'h24, 8'h01, 1);
    fork
      pulses(1);
      begin idle(2); ticks(1, 3); end
    join
    chk(ev_seen[1] == 1, "R11", "limit outranks periodic", ev_seen[1], 1);

    tag = "R12"; clear_seen();
    cfg(8'h4C, 8'h02, 8'h00, 8'h00, 0);
    pulses(3);
    chk(count == 3, "R12", "pre-reconfig count", int'(count), 3);
    cfg(8'h4D, 8'h02, 8'h00, 8'h00, 0);
    chk(count == 0, "R12", "reconfig clears", int'(count), 0);

    idle(5);
    finish_run();
  end
endmodule